// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns the system clock into a single-cycle tick at sixteen times the serial bit rate. The divisor has two parts: a 16-bit integer part and a 6-bit fractional part counted in 64ths. Software picks the divisor as the reference clock over sixteen times the baud rate. It writes the whole-number part to the integer input and the remainder, times 64 and rounded, to the fractional input. For example, 48 MHz at 115200 baud gives about 26.0417, which is an integer part of 26 and a fractional part of 3.

A 6-bit phase accumulator adds the fractional part once per tick period. Each time that sum overflows, the period that is starting is made one clock longer. Over any 64 periods from enable, the total length is exactly 64 times the integer part plus the fractional part, so the average period is the programmed non-integer divisor.

An optional bit strobe marks every sixteenth tick, which is one bit period. The divisor inputs are sampled only at a period boundary, or at the first cycle after enable. A period already counting is never shortened or stretched by a new value.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and while `enable` is low, `tick_16x` and `bit_strobe` stay 0.
- R2: The first tick appears exactly `div_int` rising edges after the edge that samples `enable` high. With `div_frac` = 0, every later period is exactly `div_int` cycles. When `div_int` > 1, each tick lasts one cycle.
- R3: Period k (k = 1 for the first period after enable) is `div_int`+1 cycles when floor(k·`div_frac`/64) > floor((k−1)·`div_frac`/64). Otherwise it is `div_int` cycles.
- R4: Any 64 consecutive periods counted from enable add up to exactly 64·`div_int` + `div_frac` cycles.
- R5: An integer part of 0, sampled at a boundary or at enable, stops the generator. No tick is produced until a non-zero value is sampled.
- R6: A change of `div_int` or `div_frac` in the middle of a period leaves that period's length unchanged. The new value takes effect from the next period.
- R7: Dropping `enable` stops ticks from the next cycle on. It also resets the fractional phase and the bit-strobe phase, so raising `enable` again starts the same as a fresh start.
- R8: `bit_strobe` is high together with the 16th, 32nd, 48th and later multiples-of-16 ticks counted from enable, and at no other time.
- R9: The boundary divisors are exact. `div_int` = 1 with `div_frac` = 0 gives a tick on every cycle, and `div_int` = 65535 gives a first period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high; clears phase when low |
| div_int | input | 16 | Integer part of the divisor, in clocks |
| div_frac | input | 6 | Fractional part of the divisor, in 64ths of a clock |
| tick_16x | output | 1 | One-cycle pulse at 16 times the baud rate |
| bit_strobe | output | 1 | One-cycle pulse on every 16th tick |

## Verification
A fault in the accumulator shows up at the ports within one 64-period window. The long periods either fall in the wrong places or the window total misses 64·int+frac by the number of lost or extra carries. A wrong reload value in the period counter changes the very next interval between ticks, so a single measured period exposes it. A strobe divider that does not clear on disable shows up within 16 ticks, because the first strobe after re-enable lands early. A divisor that is sampled mid-period changes the length of the period that is in progress.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DEF_INT_W      = 16;
  localparam int unsigned DEF_FRAC_W     = 6;
  localparam int unsigned DEF_OVERSAMPLE = 16;
endpackage

// File: rtl/baud_frac_accum.sv
module baud_frac_accum #(
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry,
  output logic [FRAC_W-1:0] phase_q
);
  logic [FRAC_W:0] sum;

  function automatic logic [FRAC_W:0] phase_add(input logic [FRAC_W-1:0] a,
                                                input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum   = phase_add(phase_q, frac);
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) phase_q <= '0;
    else if (step)       phase_q <= sum[FRAC_W-1:0];
  end

  // After an overflow the residue is below the step just added.
  AST_WRAP_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(carry && step && !clear) |-> (phase_q < $past(frac)))
    else $error("residue after wrap"); // R3
endmodule

// File: rtl/baud_period_counter.sv
module baud_period_counter #(
  parameter int unsigned INT_W = 16,
  localparam int unsigned CNT_W = INT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic [CNT_W-1:0] load_val,
  output logic             running,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  assign expire = running && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || stop) begin
      running <= 1'b0;
      cnt_q   <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt_q   <= load_val - ONE;
    end else if (running && cnt_q != '0) begin
      cnt_q   <= cnt_q - ONE;
    end
  end

  // A period longer than one clock cannot expire right after loading.
  AST_NO_EARLY_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load && !stop) && $past(load_val) != ONE) |-> !expire)
    else $error("early expire"); // R2
endmodule

// File: rtl/baud_bit_divider.sv
module baud_bit_divider #(
  parameter int unsigned OVERSAMPLE = 16,
  parameter bit          HAS_STROBE = 1'b1,
  localparam int unsigned SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic strobe
);
  generate
    if (HAS_STROBE) begin : g_strobe
      localparam logic [SUB_W-1:0] LAST = SUB_W'(OVERSAMPLE - 1);
      logic [SUB_W-1:0] sub_q;
      always_ff @(posedge clk) begin
        if (!rst_n || clear)  sub_q <= '0;
        else if (tick)        sub_q <= (sub_q == LAST) ? '0 : sub_q + SUB_W'(1);
      end
      assign strobe = tick && (sub_q == LAST);
    end else begin : g_none
      assign strobe = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned INT_W      = DEF_INT_W,
  parameter int unsigned FRAC_W     = DEF_FRAC_W,
  parameter int unsigned OVERSAMPLE = DEF_OVERSAMPLE,
  parameter bit          HAS_STROBE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick_16x,
  output logic              bit_strobe
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic              legal, boundary, load, stop;
  logic              running, expire, carry;
  logic [FRAC_W-1:0] phase;
  logic [CNT_W-1:0]  period_len;

  function automatic logic [CNT_W-1:0] period_of(input logic [INT_W-1:0] ip,
                                                 input logic c);
    return {1'b0, ip} + {{INT_W{1'b0}}, c};
  endfunction

  assign legal      = (div_int != '0);
  assign boundary   = !running || expire;
  assign load       = enable && legal && boundary;
  assign stop       = !enable || (!legal && boundary);
  assign period_len = period_of(div_int, carry);

  baud_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clear(!enable), .step(load),
    .frac(div_frac), .carry(carry), .phase_q(phase)
  );

  baud_period_counter #(.INT_W(INT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
    .load_val(period_len), .running(running), .expire(expire)
  );

  assign tick_16x = expire;

  baud_bit_divider #(.OVERSAMPLE(OVERSAMPLE), .HAS_STROBE(HAS_STROBE)) u_bits (
    .clk(clk), .rst_n(rst_n), .clear(!enable), .tick(expire), .strobe(bit_strobe)
  );

  AST_OFF_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick_16x) else $error("tick while off"); // R7
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !legal) |=> !tick_16x) else $error("tick at zero divisor"); // R5
  AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && OVERSAMPLE > 1) |=> !bit_strobe) else $error("strobe twice"); // R8
  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (phase == '0)) else $error("phase kept"); // R7
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic [15:0] div_int = '0;
  logic [5:0]  div_frac = '0;
  logic tick_16x, bit_strobe;
  int errors = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_int(div_int),
    .div_frac(div_frac), .tick_16x(tick_16x), .bit_strobe(bit_strobe)
  );

  localparam logic [21:0] VECS [6] = '{
    {16'd26, 6'd3}, {16'd1, 6'd0}, {16'd2, 6'd32},
    {16'd5, 6'd63}, {16'd3, 6'd1}, {16'd7, 6'd0}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!tick_16x && n < 70000);
  endtask

  task automatic start(input int ip, input int fp);
    @(negedge clk); enable = 1'b0; div_int = 16'(ip); div_frac = 6'(fp);
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic count_ticks(input int cycles, output int t);
    t = 0;
    for (int c = 0; c < cycles; c++) begin @(posedge clk); #1; if (tick_16x) t++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, t, sum, bad, badstr, ip, fp, exp_n, first_bad_act, first_bad_exp;
    repeat (3) @(posedge clk);
    #1 check(tick_16x == 0 && bit_strobe == 0, "R1 reset", tick_16x, 0);
    @(negedge clk); rst_n = 1'b1; div_int = 16'd4;
    count_ticks(20, t);
    check(t == 0, "R1 idle with enable low", t, 0);

    for (int v = 0; v < 6; v++) begin
      ip = int'(VECS[v][21:6]); fp = int'(VECS[v][5:0]);
      start(ip, fp);
      sum = 0; bad = 0; badstr = 0; first_bad_act = 0; first_bad_exp = 0;
      for (int k = 1; k <= 64; k++) begin
        wait_tick(n);
        exp_n = ip + (((k * fp) / 64 != ((k - 1) * fp) / 64) ? 1 : 0);
        if (n != exp_n && bad == 0) begin first_bad_act = n; first_bad_exp = exp_n; end
        if (n != exp_n) bad++;
        if (bit_strobe != (k % 16 == 0)) badstr++;
        sum += n;
      end
      check(bad == 0, (fp == 0) ? "R2 period" : "R3 long periods", first_bad_act, first_bad_exp);
      check(sum == 64 * ip + fp, "R4 window total", sum, 64 * ip + fp);
      check(badstr == 0, "R8 strobe position", badstr, 0);
      if (ip == 1) check(sum == 64, "R9 tick every cycle", sum, 64);
    end

    start(0, 5);
    count_ticks(200, t);
    check(t == 0, "R5 zero integer part", t, 0);

    start(40, 0);
    wait_tick(n);
    check(n == 40, "R2 first latency", n, 40);
    n = 0;
    do begin @(posedge clk); #1; n++; if (n == 5) div_int = 16'd10; end
    while (!tick_16x && n < 70000);
    check(n == 40, "R6 current period kept", n, 40);
    wait_tick(n);
    check(n == 10, "R6 new value next period", n, 10);

    start(2, 0);
    for (int k = 0; k < 5; k++) wait_tick(n);
    @(negedge clk); enable = 1'b0;
    count_ticks(40, t);
    check(t == 0, "R7 no ticks after disable", t, 0);
    @(negedge clk); enable = 1'b1;
    wait_tick(n);
    check(n == 2, "R7 restart latency", n, 2);
    t = 1;
    while (!bit_strobe && t < 100) begin wait_tick(n); t++; end
    check(t == 16, "R7 strobe phase cleared", t, 16);

    start(65535, 0);
    wait_tick(n);
    check(n == 65535, "R9 max integer part", n, 65535);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule